// File: doc/BRIEF.md
# Word-Serial Coefficient and Register Loader

This block fills a filter's coefficient storage and control registers through one narrow 12-bit word port. A load-enable strobe qualifies the port on every clock. Each transfer opens with an address word. The address word says whether the transfer is a coefficient set or a control register, and where it lands. The data words that follow are collected and then committed in one atomic update.

A coefficient transfer carries eight words, one per multiplier. All eight are written together, at one shared address, into eight 256-deep banks. A control transfer carries one to three words, depending on how wide its target is. The target is one of six configuration registers or one of sixteen select, round or limit registers.

The banks offer a synchronous read port that serves all eight multipliers at once. The control registers are driven straight onto output ports.

Top module: `cfgld_loader`

## Requirements
- R1: While reset is held (synchronous, active high), every control register output and every coefficient read output goes to zero, and the next enabled word is taken as an address word.
- R2: An address word with bit 11 set opens a coefficient transfer. Bits 7:0 give the bank address and bits 10:8 are ignored. The next eight enabled words go to banks 0 through 7 in that order.
- R3: A complete coefficient set is written to all eight banks at the same address on the rising edge that follows the edge sampling the eighth word. An incomplete set writes nothing.
- R4: A new address word may follow the final data word of a transfer on the very next cycle, with no idle cycle between them. Both transfers then complete.
- R5: An address word with bit 11 clear opens a control transfer. Bits 7:4 hold a type code (0 configuration, 1 select, 2 round, 3 limit) and bits 3:0 the index. A configuration or select transfer takes one data word, a limit transfer two and a round transfer three. A select register keeps bits 4:0 of its word.
- R6: Multi-word values are assembled least significant word first. For a round register, bits 7:0 of the third word fill bits 31:24 and the word's upper bits are dropped. For a limit register, the first word is the lower limit (bits 11:0) and the second word is the upper limit (bits 23:12).
- R7: A control register changes on the rising edge that follows the edge sampling its last data word. No other register changes at that edge.
- R8: A cycle with load-enable low aborts any partial transfer and writes nothing. The next enabled word is then decoded as an address word.
- R9: A control transfer with a type code of 4 to 15, or a configuration transfer with an index of 6 to 15, consumes one data word and changes no register.
- R10: The coefficient read port registers its address. The outputs show bank contents one edge after the address is presented. A read on the same edge as a write to the same address returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load enable; a word is accepted on each cycle it is high |
| ld_word | input | 12 | Address or data word |
| coef_raddr | input | 8 | Shared coefficient read address |
| coef_rdata | output | 8x12 | Read data, one 12-bit lane per bank (lane 0 in bits 11:0) |
| cfg_regs | output | 6x12 | Configuration registers |
| sel_regs | output | 16x5 | Select registers |
| rnd_regs | output | 16x32 | Round registers |
| lim_regs | output | 16x24 | Limit registers, upper limit in bits 23:12 |

## Verification
The commit of a coefficient set and a read of the same bank address can land on one clock edge. The bench provokes this by parking the read address on a location that is about to be rewritten, then streaming a new set into it. It then samples the read lanes on every cycle around the write edge. It expects the old values through the write edge and the new values only one cycle later. A second collision, a commit landing while the next back-to-back address word is decoded, is judged by the scoreboard against the exact cycle each register must change.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int WORD_W     = 12;
    localparam int NUM_BANKS  = 8;
    localparam int BANK_DEPTH = 256;
    localparam int BANK_AW    = $clog2(BANK_DEPTH);
    localparam int NUM_CFG    = 6;
    localparam int NUM_CTL    = 16;
    localparam int CTL_IW     = $clog2(NUM_CTL);
    localparam int SEL_W      = 5;
    localparam int RND_W      = 32;
    localparam int LIM_W      = 24;
    localparam int RND_WORDS  = (RND_W + WORD_W - 1) / WORD_W;
    localparam int LIM_WORDS  = (LIM_W + WORD_W - 1) / WORD_W;
    localparam int MAX_WORDS  = NUM_BANKS;
    localparam int CNT_W      = $clog2(MAX_WORDS + 1);

    // address word layout
    localparam int MODE_BIT   = 11;
    localparam int TYPE_LSB   = 4;
    localparam int TYPE_W     = 4;

    localparam logic [TYPE_W-1:0] CODE_CFG = 4'd0;
    localparam logic [TYPE_W-1:0] CODE_SEL = 4'd1;
    localparam logic [TYPE_W-1:0] CODE_RND = 4'd2;
    localparam logic [TYPE_W-1:0] CODE_LIM = 4'd3;

    typedef enum logic [2:0] {
        K_COEF = 3'd0,
        K_CFG  = 3'd1,
        K_SEL  = 3'd2,
        K_RND  = 3'd3,
        K_LIM  = 3'd4,
        K_DROP = 3'd5
    } kind_e;

    typedef logic [MAX_WORDS-1:0][WORD_W-1:0] payload_t;

    typedef struct packed {
        logic               valid;
        kind_e              kind;
        logic [BANK_AW-1:0] slot;
        payload_t           data;
    } commit_t;

    function automatic kind_e decode_kind(input logic [WORD_W-1:0] w);
        logic [TYPE_W-1:0] code;
        logic [CTL_IW-1:0] idx;
        code = w[TYPE_LSB +: TYPE_W];
        idx  = w[CTL_IW-1:0];
        if (w[MODE_BIT]) return K_COEF;
        case (code)
            CODE_CFG: return (idx < CTL_IW'(NUM_CFG)) ? K_CFG : K_DROP;
            CODE_SEL: return K_SEL;
            CODE_RND: return K_RND;
            CODE_LIM: return K_LIM;
            default:  return K_DROP;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] words_needed(input kind_e k);
        case (k)
            K_COEF:  return CNT_W'(NUM_BANKS);
            K_RND:   return CNT_W'(RND_WORDS);
            K_LIM:   return CNT_W'(LIM_WORDS);
            default: return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/cfgld_seq_decoder.sv
module cfgld_seq_decoder
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    output commit_t           commit_o
);

    typedef enum logic {ST_ADDR, ST_DATA} st_e;

    st_e                st_q;
    kind_e              kind_q;
    logic [BANK_AW-1:0] slot_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   need_q;
    payload_t           buf_q;
    payload_t           buf_next;
    logic               last_word;
    kind_e              new_kind;

    assign new_kind  = decode_kind(ld_word);
    assign last_word = ld_en && (st_q == ST_DATA) && (cnt_q == (need_q - CNT_W'(1)));

    always_comb begin
        buf_next = buf_q;
        for (int i = 0; i < MAX_WORDS; i++) begin
            if (cnt_q == CNT_W'(i)) buf_next[i] = ld_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_ADDR;
            kind_q   <= K_DROP;
            slot_q   <= '0;
            cnt_q    <= '0;
            need_q   <= '0;
            buf_q    <= '0;
            commit_o <= '0;
        end else begin
            commit_o.valid <= 1'b0;
            if (!ld_en) begin
                st_q  <= ST_ADDR;
                cnt_q <= '0;
            end else if (st_q == ST_ADDR) begin
                kind_q <= new_kind;
                slot_q <= ld_word[BANK_AW-1:0];
                need_q <= words_needed(new_kind);
                cnt_q  <= '0;
                buf_q  <= '0;
                st_q   <= ST_DATA;
            end else begin
                buf_q <= buf_next;
                if (last_word) begin
                    st_q           <= ST_ADDR;
                    cnt_q          <= '0;
                    commit_o.valid <= 1'b1;
                    commit_o.kind  <= kind_q;
                    commit_o.slot  <= slot_q;
                    commit_o.data  <= buf_next;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R8: a dropped enable returns the decoder to address decoding
    a_r8_abort_to_address: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> (st_q == ST_ADDR && cnt_q == '0));

    // R8: a commit only ever follows an accepted word
    a_r8_commit_needs_enable: assert property (@(posedge clk) disable iff (rst)
        commit_o.valid |-> $past(ld_en));

    // R5: the word counter never runs past the target's word count
    a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA) |-> (cnt_q < need_q));

endmodule

// File: rtl/cfgld_coef_banks.sv
module cfgld_coef_banks
    import cfgld_pkg::*;
#(
    parameter int BANKS = NUM_BANKS,
    parameter int DEPTH = BANK_DEPTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  payload_t                    wdata,
    input  logic [AW-1:0]               raddr,
    output logic [BANKS-1:0][WORD_W-1:0] rdata
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];
        logic [WORD_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata[b];
            if (rst) rd_q <= '0;
            else     rd_q <= mem[raddr];
        end

        assign rdata[b] = rd_q;

        // R3: every bank takes its own lane of the committed set
        a_r3_bank_lane_written: assert property (@(posedge clk) disable iff (rst)
            $past(we) |-> (mem[$past(waddr)] == $past(wdata[b])));
    end

endmodule

// File: rtl/cfgld_ctrl_regs.sv
module cfgld_ctrl_regs
    import cfgld_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  commit_t                          cm,
    output logic [NUM_CFG-1:0][WORD_W-1:0]   cfg_q,
    output logic [NUM_CTL-1:0][SEL_W-1:0]    sel_q,
    output logic [NUM_CTL-1:0][RND_W-1:0]    rnd_q,
    output logic [NUM_CTL-1:0][LIM_W-1:0]    lim_q
);

    logic [CTL_IW-1:0] idx;
    assign idx = cm.slot[CTL_IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sel_q <= '0;
            rnd_q <= '0;
            lim_q <= '0;
        end else if (cm.valid) begin
            case (cm.kind)
                K_CFG: begin
                    for (int i = 0; i < NUM_CFG; i++)
                        if (idx == CTL_IW'(i)) cfg_q[i] <= cm.data[0];
                end
                K_SEL: begin
                    for (int i = 0; i < NUM_CTL; i++)
                        if (idx == CTL_IW'(i)) sel_q[i] <= SEL_W'(cm.data[0]);
                end
                K_RND: begin
                    for (int i = 0; i < NUM_CTL; i++)
                        if (idx == CTL_IW'(i)) rnd_q[i] <= RND_W'(cm.data);
                end
                K_LIM: begin
                    for (int i = 0; i < NUM_CTL; i++)
                        if (idx == CTL_IW'(i)) lim_q[i] <= LIM_W'(cm.data);
                end
                default: ;
            endcase
        end
    end

    // R7: registers hold unless a commit was presented on the previous edge
    a_r7_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !$past(cm.valid) |-> ($stable(cfg_q) && $stable(sel_q) && $stable(rnd_q) && $stable(lim_q)));

    // R6: the least significant round word lands in bits 11:0
    a_r6_round_low_word: assert property (@(posedge clk) disable iff (rst)
        $past(cm.valid && cm.kind == K_RND) |->
            (rnd_q[$past(idx)][WORD_W-1:0] == $past(cm.data[0])));

    // R9: a dropped transfer changes nothing
    a_r9_drop_no_change: assert property (@(posedge clk) disable iff (rst)
        $past(cm.valid && (cm.kind == K_DROP || cm.kind == K_COEF)) |->
            ($stable(cfg_q) && $stable(sel_q) && $stable(rnd_q) && $stable(lim_q)));

endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
    import cfgld_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ld_en,
    input  logic [WORD_W-1:0]                 ld_word,
    input  logic [BANK_AW-1:0]                coef_raddr,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]  coef_rdata,
    output logic [NUM_CFG-1:0][WORD_W-1:0]    cfg_regs,
    output logic [NUM_CTL-1:0][SEL_W-1:0]     sel_regs,
    output logic [NUM_CTL-1:0][RND_W-1:0]     rnd_regs,
    output logic [NUM_CTL-1:0][LIM_W-1:0]     lim_regs
);

    commit_t cm;
    logic    coef_we;

    cfgld_seq_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_word  (ld_word),
        .commit_o (cm)
    );

    assign coef_we = cm.valid && (cm.kind == K_COEF);

    cfgld_coef_banks #(
        .BANKS (NUM_BANKS),
        .DEPTH (BANK_DEPTH),
        .AW    (BANK_AW)
    ) u_banks (
        .clk   (clk),
        .rst   (rst),
        .we    (coef_we),
        .waddr (cm.slot),
        .wdata (cm.data),
        .raddr (coef_raddr),
        .rdata (coef_rdata)
    );

    cfgld_ctrl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .cm    (cm),
        .cfg_q (cfg_regs),
        .sel_q (sel_regs),
        .rnd_q (rnd_regs),
        .lim_q (lim_regs)
    );

    // R3: a coefficient commit never targets the control registers
    a_r3_coef_skips_ctrl: assert property (@(posedge clk) disable iff (rst)
        $past(coef_we) |-> ($stable(sel_regs) && $stable(rnd_regs) && $stable(lim_regs) && $stable(cfg_regs)));

endmodule

// File: tb/cfgld_loader_bench.sv
module cfgld_loader_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_en = 1'b0;
    logic [11:0]       ld_word = '0;
    logic [7:0]        coef_raddr = '0;
    logic [7:0][11:0]  coef_rdata;
    logic [5:0][11:0]  cfg_regs;
    logic [15:0][4:0]  sel_regs;
    logic [15:0][31:0] rnd_regs;
    logic [15:0][23:0] lim_regs;

    cfgld_loader u_cfgld_loader (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_word(ld_word),
        .coef_raddr(coef_raddr), .coef_rdata(coef_rdata),
        .cfg_regs(cfg_regs), .sel_regs(sel_regs),
        .rnd_regs(rnd_regs), .lim_regs(lim_regs)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        int               due;
        int               kind;   // 0 coef, 1 cfg, 2 sel, 3 rnd, 4 lim
        int               idx;
        logic [31:0]      val;
        logic [7:0][11:0] cv;
        string            req;
    } item_t;

    item_t sb_q[$];

    logic [11:0] exp_cfg  [6];
    logic [4:0]  exp_sel  [16];
    logic [31:0] exp_rnd  [16];
    logic [23:0] exp_lim  [16];
    logic [11:0] exp_coef [8][256];

    // ---------------- driver ----------------
    task automatic put_word(input logic [11:0] w);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_word = w;
    endtask

    task automatic gap();
        @(negedge clk);
        ld_en   = 1'b0;
        ld_word = '0;
    endtask

    task automatic send_coef(input logic [11:0] aw, input logic [7:0][11:0] v, input string req);
        item_t it;
        put_word(aw);
        for (int k = 0; k < 8; k++) put_word(v[k]);
        it.due = cyc + 2; it.kind = 0; it.idx = int'(aw[7:0]);
        it.val = '0; it.cv = v; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic send_ctrl(input logic [3:0] code, input logic [3:0] idx, input int n,
                             input logic [2:0][11:0] w, input int kind,
                             input logic [31:0] val, input string req);
        item_t it;
        put_word({4'b0000, code, idx});
        for (int k = 0; k < n; k++) put_word(w[k]);
        if (kind > 0) begin
            it.due = cyc + 2; it.kind = kind; it.idx = int'(idx);
            it.val = val; it.cv = '0; it.req = req;
            sb_q.push_back(it);
        end
    endtask

    function automatic logic [7:0][11:0] make_set(input logic [11:0] base);
        logic [7:0][11:0] v;
        for (int k = 0; k < 8; k++) v[k] = base + 12'(k * 'h101);
        return v;
    endfunction

    // ---------------- monitor ----------------
    function automatic bit ctrl_diff(output string m);
        for (int i = 0; i < 6; i++)
            if (cfg_regs[i] !== exp_cfg[i]) begin
                m = $sformatf("cfg[%0d] actual %h expected %h", i, cfg_regs[i], exp_cfg[i]); return 1'b1;
            end
        for (int i = 0; i < 16; i++) begin
            if (sel_regs[i] !== exp_sel[i]) begin
                m = $sformatf("sel[%0d] actual %h expected %h", i, sel_regs[i], exp_sel[i]); return 1'b1;
            end
            if (rnd_regs[i] !== exp_rnd[i]) begin
                m = $sformatf("rnd[%0d] actual %h expected %h", i, rnd_regs[i], exp_rnd[i]); return 1'b1;
            end
            if (lim_regs[i] !== exp_lim[i]) begin
                m = $sformatf("lim[%0d] actual %h expected %h", i, lim_regs[i], exp_lim[i]); return 1'b1;
            end
        end
        m = "";
        return 1'b0;
    endfunction

    item_t mon_it;
    string mon_req;
    string mon_msg;
    bit    mon_hit;
    int    mon_prints = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            mon_hit = 1'b0;
            mon_req = "R7";
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                mon_it = sb_q.pop_front();
                mon_hit = 1'b1;
                mon_req = mon_it.req;
                case (mon_it.kind)
                    0: for (int k = 0; k < 8; k++) exp_coef[k][mon_it.idx] = mon_it.cv[k];
                    1: exp_cfg[mon_it.idx] = mon_it.val[11:0];
                    2: exp_sel[mon_it.idx] = mon_it.val[4:0];
                    3: exp_rnd[mon_it.idx] = mon_it.val;
                    default: exp_lim[mon_it.idx] = mon_it.val[23:0];
                endcase
            end
            if (ctrl_diff(mon_msg)) begin
                checks++;
                errors++;
                if (mon_prints < 20) $display("FAIL %s: cycle %0d %s", mon_req, cyc, mon_msg);
                mon_prints++;
            end else if (mon_hit) begin
                checks++;
            end
        end
    end

    // ---------------- direct checks ----------------
    task automatic cmp_lanes(input logic [7:0][11:0] expv, input string req);
        checks++;
        for (int k = 0; k < 8; k++)
            if (coef_rdata[k] !== expv[k]) begin
                errors++;
                $display("FAIL %s: bank %0d actual %h expected %h", req, k, coef_rdata[k], expv[k]);
                return;
            end
    endtask

    task automatic check_coef(input logic [7:0] a, input string req);
        logic [7:0][11:0] e;
        @(negedge clk);
        coef_raddr = a;
        @(negedge clk);
        for (int k = 0; k < 8; k++) e[k] = exp_coef[k][a];
        cmp_lanes(e, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0][11:0] set_a, set_b, set_c, set_d, set_x;
    string rmsg;

    initial begin
        for (int i = 0; i < 6; i++)  exp_cfg[i] = '0;
        for (int i = 0; i < 16; i++) begin exp_sel[i] = '0; exp_rnd[i] = '0; exp_lim[i] = '0; end
        for (int k = 0; k < 8; k++) for (int a = 0; a < 256; a++) exp_coef[k][a] = '0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every output
        checks++;
        if (ctrl_diff(rmsg)) begin errors++; $display("FAIL R1: %s", rmsg); end
        cmp_lanes('0, "R1");
        mon_on = 1'b1;

        // R2 R3: one coefficient set
        set_a = make_set(12'h100);
        send_coef(12'h825, set_a, "R3");
        gap();
        repeat (2) @(negedge clk);
        check_coef(8'h25, "R3");

        // R2: bits 10:8 of the address word ignored
        set_b = make_set(12'h300);
        send_coef(12'hF4A, set_b, "R2");
        gap();
        repeat (2) @(negedge clk);
        check_coef(8'h4A, "R2");

        // R4: back-to-back sets then a control write, no idle cycle
        set_c = make_set(12'h510);
        set_d = make_set(12'h7A3);
        send_coef(12'h801, set_c, "R4");
        send_coef(12'h8FF, set_d, "R4");
        send_ctrl(CODE_CFG_B, 4'd0, 1, {12'h0, 12'h0, 12'h5A5}, 1, 32'h5A5, "R4");
        gap();
        repeat (2) @(negedge clk);
        check_coef(8'h01, "R4");
        check_coef(8'hFF, "R4");

        // R5 R6: each control type
        send_ctrl(CODE_CFG_B, 4'd3, 1, {12'h0, 12'h0, 12'hABC}, 1, 32'hABC, "R5");
        send_ctrl(4'd1, 4'd7, 1, {12'h0, 12'h0, 12'hFFF}, 2, 32'h1F, "R5");
        send_ctrl(4'd2, 4'd12, 3, {12'hF89, 12'h456, 12'h123}, 3, 32'h8945_6123, "R6");
        send_ctrl(4'd3, 4'd15, 2, {12'h0, 12'hFE0, 12'h010}, 4, 32'h00FE_0010, "R6");
        gap();
        send_ctrl(4'd2, 4'd0, 3, {12'h001, 12'hFFF, 12'h800}, 3, 32'h01FF_F800, "R6");
        gap();
        repeat (3) @(negedge clk);

        // R8: aborted round transfer, then the next word is an address
        put_word({4'b0000, 4'd2, 4'd1});
        put_word(12'h111);
        put_word(12'h222);
        gap();
        send_ctrl(4'd1, 4'd2, 1, {12'h0, 12'h0, 12'h015}, 2, 32'h15, "R8");
        gap();
        repeat (3) @(negedge clk);
        checks++;
        if (rnd_regs[1] !== 32'h0) begin
            errors++;
            $display("FAIL R8: rnd[1] actual %h expected 0", rnd_regs[1]);
        end

        // R8: aborted coefficient set leaves the banks alone
        set_x = make_set(12'hE00);
        put_word(12'h825);
        for (int k = 0; k < 5; k++) put_word(set_x[k]);
        gap();
        repeat (3) @(negedge clk);
        check_coef(8'h25, "R8");

        // R9: unknown type code and out-of-range configuration index
        send_ctrl(4'd5, 4'd2, 1, {12'h0, 12'h0, 12'h777}, 0, 32'h0, "R9");
        send_ctrl(4'd1, 4'd3, 1, {12'h0, 12'h0, 12'h00A}, 2, 32'h0A, "R9");
        send_ctrl(CODE_CFG_B, 4'd7, 1, {12'h0, 12'h0, 12'h999}, 0, 32'h0, "R9");
        send_ctrl(4'd3, 4'd4, 2, {12'h0, 12'h123, 12'h456}, 4, 32'h0012_3456, "R9");
        gap();
        repeat (4) @(negedge clk);

        // R10: read of an address while it is rewritten
        @(negedge clk);
        coef_raddr = 8'h25;
        @(negedge clk);
        cmp_lanes(set_a, "R10");
        set_x = make_set(12'hC0F);
        send_coef(12'h825, set_x, "R10");
        gap();
        cmp_lanes(set_a, "R10");
        @(negedge clk);
        cmp_lanes(set_a, "R10");
        @(negedge clk);
        cmp_lanes(set_x, "R10");

        repeat (6) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [3:0] CODE_CFG_B = 4'd0;

endmodule